// File: doc/BRIEF.md
# Exclusive Split-L1 Placement Selector

This block sits in front of the coherence controller of a private three-level hierarchy. The hierarchy has an instruction L1, a data L1 and an L2, and any line lives in at most one of the three. For the request at the head of the processor queue, the block looks at the lookup results of all three tag arrays and picks exactly one event for the controller to run next. That event may move a line that sits in the wrong L1 down to the L2, or make room in the L2 by replacing its victim. It may also pull a line up from the L2 into the correct L1, cascade an L1 victim into the L2, or pass the request on as a plain load, fetch or store. No coherence request is issued until a line reaches the correct L1 or is found absent from the whole hierarchy.

The array lookups arrive as inputs: a hit flag, a free-way flag and a victim address for each L1. The L2 answers two queries: one for the request address and one for the address of the relevant L1 victim. The decision is combinational. It is captured in an output register and held until the controller accepts it. The controller re-presents the same queue head until that request finally resolves to a plain event, so one request may produce a series of events. If a tag is reported in two arrays at once, the block raises an error flag and issues nothing.

Top module: `excl_place_sel`

## Requirements
- R1: During reset and in the first cycle after reset, `evt_valid` and `err` are both 0.
- R2: A fetch (`req_kind`=1) that hits the data L1, or a data access (`req_kind` 0, 2 or 3) that hits the instruction L1, raises event 3 (move L1 line to L2) at `req_addr` when `l2_free_req` is 1.
- R3: In the R2 situation with `l2_free_req` at 0, the block raises event 4 (L2 replacement) at `l2_victim_req`.
- R4: A hit in the correct L1 raises the plain event at `req_addr`. A load (`req_kind`=0) gives event 0, a fetch (1) gives event 1, and a store (2) or atomic (3) gives event 2.
- R5: A miss in the correct L1 when that L1 has a free way and `l2_hit` is 1 raises event 5 (L2 to data L1) for data accesses and event 6 (L2 to instruction L1) for fetches, at `req_addr`.
- R6: A miss in the correct L1 when that L1 has a free way and `l2_hit` is 0 raises the plain event of R4 at `req_addr`.
- R7: A miss in the correct L1 when that L1 has no free way and `l2_free_l1v` is 1 raises event 3 at the victim address of that L1. This is `il1_victim` for fetches and `dl1_victim` otherwise. The free flag of the other L1 has no effect.
- R8: A miss in the correct L1 when that L1 has no free way and `l2_free_l1v` is 0 raises event 4 at `l2_victim_l1v`.
- R9: When more than one of `il1_hit`, `dl1_hit` and `l2_hit` is 1 with `req_valid` high, `err` is 1 on the next cycle and no event is raised for that input. Once the conflict clears, `err` returns to 0 and a decision is made at the same edge.
- R10: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid`, `evt_code` and `evt_addr` keep their values.
- R11: A decision is captured at the first rising edge where `req_valid` is 1, no conflict exists and no event is held, and it appears on the outputs after that edge. After acceptance (`evt_valid` and `evt_ready` both 1 at an edge), `evt_valid` is 0 for one cycle before the next decision.
- R12: With `req_valid` at 0, no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is at the head of the processor queue |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr | input | ADDR_W | Line address of the request |
| il1_hit | input | 1 | Request tag present in the instruction L1 |
| il1_free | input | 1 | Instruction L1 set of the request has a free way |
| il1_victim | input | ADDR_W | Instruction L1 victim for the request set |
| dl1_hit | input | 1 | Request tag present in the data L1 |
| dl1_free | input | 1 | Data L1 set of the request has a free way |
| dl1_victim | input | ADDR_W | Data L1 victim for the request set |
| l2_hit | input | 1 | Request tag present in the L2 |
| l2_free_req | input | 1 | L2 set of the request address has a free way |
| l2_victim_req | input | ADDR_W | L2 victim for the request address |
| l2_free_l1v | input | 1 | L2 set of the relevant L1 victim has a free way |
| l2_victim_l1v | input | ADDR_W | L2 victim for the relevant L1 victim address |
| evt_valid | output | 1 | An event is held for the controller |
| evt_code | output | 3 | Event code (0..6, see requirements) |
| evt_addr | output | ADDR_W | Line address the event applies to |
| evt_ready | input | 1 | Controller accepts the held event |
| err | output | 1 | Tag reported in more than one array |

## Verification
The checker watches the output handshake on every cycle. It checks that a held event stays stable and that a one-cycle gap follows each acceptance. It also checks that an idle queue produces nothing, that a multi-array tag sets the error flag and blocks issue, that codes stay in range, and that a clean load hit decodes to a load. The bench scenarios are needed to show that each lookup combination picks the right event and the right one of the five candidate addresses. They also show that the fetch and data paths use their own L1's free flag and victim, and that a decision made right after a conflict clears is correct.

// File: rtl/xps_pkg.sv
package xps_pkg;

    localparam int ADDR_W_DEF = 32;

    typedef enum logic [1:0] {
        RK_LOAD   = 2'd0,
        RK_FETCH  = 2'd1,
        RK_STORE  = 2'd2,
        RK_ATOMIC = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        EV_LOAD      = 3'd0,
        EV_FETCH     = 3'd1,
        EV_STORE     = 3'd2,
        EV_L1_TO_L2  = 3'd3,
        EV_L2_REPL   = 3'd4,
        EV_L2_TO_DL1 = 3'd5,
        EV_L2_TO_IL1 = 3'd6
    } evt_e;

    localparam int N_SIDES  = 2;
    localparam int SIDE_D   = 0;
    localparam int SIDE_I   = 1;
    localparam int N_ARRAYS = 3;

    typedef struct packed {
        logic hit;
        logic free;
    } l1_stat_t;

    function automatic logic is_fetch(req_kind_e k);
        return k == RK_FETCH;
    endfunction

    function automatic evt_e plain_event(req_kind_e k);
        case (k)
            RK_LOAD:  return EV_LOAD;
            RK_FETCH: return EV_FETCH;
            default:  return EV_STORE;
        endcase
    endfunction

    function automatic evt_e fill_event(req_kind_e k);
        return is_fetch(k) ? EV_L2_TO_IL1 : EV_L2_TO_DL1;
    endfunction

endpackage

// File: rtl/xps_side_mux.sv
module xps_side_mux
    import xps_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              fetch,
    input  l1_stat_t          il1_stat,
    input  logic [ADDR_W-1:0] il1_victim,
    input  l1_stat_t          dl1_stat,
    input  logic [ADDR_W-1:0] dl1_victim,
    output l1_stat_t          own_stat,
    output logic [ADDR_W-1:0] own_victim,
    output logic              opp_hit
);
    l1_stat_t          stat_a [N_SIDES];
    logic [ADDR_W-1:0] vic_a  [N_SIDES];

    assign stat_a[SIDE_D] = dl1_stat;
    assign stat_a[SIDE_I] = il1_stat;
    assign vic_a[SIDE_D]  = dl1_victim;
    assign vic_a[SIDE_I]  = il1_victim;

    logic [N_SIDES-1:0] sel_own;
    logic [N_SIDES-1:0] opp_hits;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        assign sel_own[s]  = (s == SIDE_I) ? fetch : !fetch;
        assign opp_hits[s] = !sel_own[s] && stat_a[s].hit;
    end

    always_comb begin
        own_stat   = '0;
        own_victim = '0;
        for (int s = 0; s < N_SIDES; s++) begin
            if (sel_own[s]) begin
                own_stat   = stat_a[s];
                own_victim = vic_a[s];
            end
        end
    end

    assign opp_hit = |opp_hits;
endmodule

// File: rtl/xps_decide.sv
module xps_decide
    import xps_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  l1_stat_t          own_stat,
    input  logic [ADDR_W-1:0] own_victim,
    input  logic              opp_hit,
    input  logic              l2_hit,
    input  logic              l2_free_req,
    input  logic [ADDR_W-1:0] l2_victim_req,
    input  logic              l2_free_l1v,
    input  logic [ADDR_W-1:0] l2_victim_l1v,
    output evt_e              code,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        code = plain_event(kind);
        addr = req_addr;
        if (opp_hit) begin
            // line in the wrong L1: push it down first
            if (l2_free_req) begin
                code = EV_L1_TO_L2;
                addr = req_addr;
            end else begin
                code = EV_L2_REPL;
                addr = l2_victim_req;
            end
        end else if (own_stat.hit) begin
            code = plain_event(kind);
            addr = req_addr;
        end else if (own_stat.free) begin
            code = l2_hit ? fill_event(kind) : plain_event(kind);
            addr = req_addr;
        end else if (l2_free_l1v) begin
            code = EV_L1_TO_L2;
            addr = own_victim;
        end else begin
            code = EV_L2_REPL;
            addr = l2_victim_l1v;
        end
    end
endmodule

// File: rtl/xps_hold.sv
module xps_hold
    import xps_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  evt_e              d_code,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              ready,
    output logic              q_valid,
    output evt_e              q_code,
    output logic [ADDR_W-1:0] q_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_code  <= EV_LOAD;
            q_addr  <= '0;
        end else if (q_valid) begin
            if (ready) q_valid <= 1'b0;
        end else if (load) begin
            q_valid <= 1'b1;
            q_code  <= d_code;
            q_addr  <= d_addr;
        end
    end
endmodule

// File: rtl/excl_place_sel.sv
module excl_place_sel
    import xps_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              il1_hit,
    input  logic              il1_free,
    input  logic [ADDR_W-1:0] il1_victim,
    input  logic              dl1_hit,
    input  logic              dl1_free,
    input  logic [ADDR_W-1:0] dl1_victim,
    input  logic              l2_hit,
    input  logic              l2_free_req,
    input  logic [ADDR_W-1:0] l2_victim_req,
    input  logic              l2_free_l1v,
    input  logic [ADDR_W-1:0] l2_victim_l1v,
    output logic              evt_valid,
    output logic [2:0]        evt_code,
    output logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_ready,
    output logic              err
);
    localparam int CNT_W = $clog2(N_ARRAYS + 1);

    req_kind_e         kind;
    l1_stat_t          il1_stat, dl1_stat, own_stat;
    logic [ADDR_W-1:0] own_victim;
    logic              opp_hit;
    evt_e              dec_code, held_code;
    logic [ADDR_W-1:0] dec_addr;
    logic [N_ARRAYS-1:0] present;
    logic [CNT_W-1:0]  n_present;
    logic              multi;
    logic              load;

    assign kind     = req_kind_e'(req_kind);
    assign il1_stat = '{hit: il1_hit, free: il1_free};
    assign dl1_stat = '{hit: dl1_hit, free: dl1_free};

    assign present = {l2_hit, dl1_hit, il1_hit};

    always_comb begin
        n_present = '0;
        for (int a = 0; a < N_ARRAYS; a++) n_present = n_present + CNT_W'(present[a]);
    end

    assign multi = n_present > CNT_W'(1);
    assign load  = req_valid && !multi;

    xps_side_mux #(.ADDR_W(ADDR_W)) side_i (
        .fetch      (is_fetch(kind)),
        .il1_stat   (il1_stat),
        .il1_victim (il1_victim),
        .dl1_stat   (dl1_stat),
        .dl1_victim (dl1_victim),
        .own_stat   (own_stat),
        .own_victim (own_victim),
        .opp_hit    (opp_hit)
    );

    xps_decide #(.ADDR_W(ADDR_W)) dec_i (
        .kind          (kind),
        .req_addr      (req_addr),
        .own_stat      (own_stat),
        .own_victim    (own_victim),
        .opp_hit       (opp_hit),
        .l2_hit        (l2_hit),
        .l2_free_req   (l2_free_req),
        .l2_victim_req (l2_victim_req),
        .l2_free_l1v   (l2_free_l1v),
        .l2_victim_l1v (l2_victim_l1v),
        .code          (dec_code),
        .addr          (dec_addr)
    );

    xps_hold #(.ADDR_W(ADDR_W)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .d_code  (dec_code),
        .d_addr  (dec_addr),
        .ready   (evt_ready),
        .q_valid (evt_valid),
        .q_code  (held_code),
        .q_addr  (evt_addr)
    );

    assign evt_code = held_code;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= req_valid && multi;
    end
endmodule

// File: rtl/excl_place_sel_chk.sv
module excl_place_sel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              il1_hit,
    input logic              dl1_hit,
    input logic              l2_hit,
    input logic              evt_valid,
    input logic [2:0]        evt_code,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              evt_ready,
    input logic              err
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!evt_valid && !err)); // R1

    AST_LOAD_HIT_CODE: assert property (@(posedge clk) disable iff (rst)
        ($rose(evt_valid) && $past(req_valid && req_kind == 2'd0 && dl1_hit && !il1_hit && !l2_hit))
        |-> (evt_code == 3'd0 && evt_addr == $past(req_addr))); // R4

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> evt_code <= 3'd6); // R4

    AST_ERR_ON_MULTI: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $countones({il1_hit, dl1_hit, l2_hit}) > 1) |=> err); // R9

    AST_NO_EVT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        err |-> !$rose(evt_valid)); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_addr))); // R10

    AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_ready) |=> !evt_valid); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!evt_valid && !req_valid) |=> !evt_valid); // R12
endmodule

bind excl_place_sel excl_place_sel_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .il1_hit   (il1_hit),
    .dl1_hit   (dl1_hit),
    .l2_hit    (l2_hit),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_addr  (evt_addr),
    .evt_ready (evt_ready),
    .err       (err)
);

// File: tb/excl_place_sel_tb_top.sv
module excl_place_sel_tb_top;
    localparam int AW = 32;
    localparam logic [AW-1:0] A_REQ = 32'h0000_1040;
    localparam logic [AW-1:0] A_IV  = 32'h0000_2080;
    localparam logic [AW-1:0] A_DV  = 32'h0000_30C0;
    localparam logic [AW-1:0] A_L2R = 32'h0000_4100;
    localparam logic [AW-1:0] A_L2V = 32'h0000_5140;

    typedef struct packed {
        logic [1:0] kind;
        logic       il1h, il1f, dl1h, dl1f, l2h, l2fr, l2fv;
        logic [2:0] code;
        logic [1:0] asel; // 0 req, 1 l2 victim of req, 2 own L1 victim, 3 l2 victim of L1 victim
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0,1'b0, 3'd0, 2'd0, 4'd4},  // R4 load hit
        '{2'd1, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0, 3'd1, 2'd0, 4'd4},  // R4 fetch hit
        '{2'd2, 1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0,1'b0, 3'd2, 2'd0, 4'd4},  // R4 store hit
        '{2'd3, 1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0,1'b0, 3'd2, 2'd0, 4'd4},  // R4 atomic as store
        '{2'd1, 1'b0,1'b1, 1'b1,1'b1, 1'b0,1'b1,1'b0, 3'd3, 2'd0, 4'd2},  // R2 fetch in data L1
        '{2'd0, 1'b1,1'b1, 1'b0,1'b1, 1'b0,1'b1,1'b0, 3'd3, 2'd0, 4'd2},  // R2 load in instr L1
        '{2'd2, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b1, 3'd4, 2'd1, 4'd3},  // R3 no L2 room
        '{2'd0, 1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0,1'b0, 3'd5, 2'd0, 4'd5},  // R5 fill data L1
        '{2'd1, 1'b0,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 3'd6, 2'd0, 4'd5},  // R5 fill instr L1
        '{2'd2, 1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b1,1'b1, 3'd2, 2'd0, 4'd6},  // R6 store miss
        '{2'd1, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 3'd1, 2'd0, 4'd6},  // R6 fetch miss
        '{2'd0, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b1, 3'd3, 2'd2, 4'd7},  // R7 data victim down
        '{2'd1, 1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0,1'b1, 3'd3, 2'd2, 4'd7},  // R7 instr victim down
        '{2'd3, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1,1'b0, 3'd4, 2'd3, 4'd8},  // R8 data cascade
        '{2'd1, 1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b1,1'b0, 3'd4, 2'd3, 4'd8}   // R8 instr cascade
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = A_REQ;
    logic          il1_hit = 1'b0, il1_free = 1'b0;
    logic [AW-1:0] il1_victim = A_IV;
    logic          dl1_hit = 1'b0, dl1_free = 1'b0;
    logic [AW-1:0] dl1_victim = A_DV;
    logic          l2_hit = 1'b0, l2_free_req = 1'b0;
    logic [AW-1:0] l2_victim_req = A_L2R;
    logic          l2_free_l1v = 1'b0;
    logic [AW-1:0] l2_victim_l1v = A_L2V;
    logic          evt_valid;
    logic [2:0]    evt_code;
    logic [AW-1:0] evt_addr;
    logic          evt_ready = 1'b0;
    logic          err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    excl_place_sel #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .il1_hit(il1_hit), .il1_free(il1_free), .il1_victim(il1_victim),
        .dl1_hit(dl1_hit), .dl1_free(dl1_free), .dl1_victim(dl1_victim),
        .l2_hit(l2_hit), .l2_free_req(l2_free_req), .l2_victim_req(l2_victim_req),
        .l2_free_l1v(l2_free_l1v), .l2_victim_l1v(l2_victim_l1v),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_addr(evt_addr),
        .evt_ready(evt_ready), .err(err)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_lookup();
        il1_hit = 0; il1_free = 0; dl1_hit = 0; dl1_free = 0;
        l2_hit = 0; l2_free_req = 0; l2_free_l1v = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        // R1: outputs idle in reset
        check(evt_valid == 0, "R1", "evt_valid in reset", 64'(evt_valid), 0);
        check(err == 0, "R1", "err in reset", 64'(err), 0);
        rst = 0;
        cyc();
        check(evt_valid == 0 && err == 0, "R1", "idle after reset", 64'({evt_valid, err}), 0);

        // R12: lookups present but no request
        dl1_hit = 1;
        repeat (3) cyc();
        check(evt_valid == 0, "R12", "no event without request", 64'(evt_valid), 0);
        clear_lookup();

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [AW-1:0] ea;
            string rs;
            v = VECS[i];
            rs = $sformatf("R%0d", v.rq);
            case (v.asel)
                2'd0: ea = A_REQ;
                2'd1: ea = A_L2R;
                2'd2: ea = (v.kind == 2'd1) ? A_IV : A_DV;
                default: ea = A_L2V;
            endcase
            req_kind = v.kind;
            il1_hit = v.il1h; il1_free = v.il1f; dl1_hit = v.dl1h; dl1_free = v.dl1f;
            l2_hit = v.l2h; l2_free_req = v.l2fr; l2_free_l1v = v.l2fv;
            req_valid = 1;
            cyc();
            check(evt_valid == 1, rs, $sformatf("vec %0d valid", i), 64'(evt_valid), 1);
            check(evt_code == v.code, rs, $sformatf("vec %0d code", i), 64'(evt_code), 64'(v.code));
            check(evt_addr == ea, rs, $sformatf("vec %0d addr", i), 64'(evt_addr), 64'(ea));
            cyc();
            // R10: held while not ready
            check(evt_valid == 1 && evt_code == v.code && evt_addr == ea, "R10",
                  $sformatf("vec %0d hold", i), 64'({evt_valid, evt_code}), 64'({1'b1, v.code}));
            evt_ready = 1;
            cyc();
            evt_ready = 0;
            req_valid = 0;
            clear_lookup();
            check(evt_valid == 0, "R11", $sformatf("vec %0d accepted", i), 64'(evt_valid), 0);
            cyc();
        end

        // R9: conflicting presence blocks issue
        req_kind = 2'd0; dl1_hit = 1; l2_hit = 1; req_valid = 1;
        cyc();
        check(err == 1, "R9", "err on double presence", 64'(err), 1);
        check(evt_valid == 0, "R9", "no event on conflict", 64'(evt_valid), 0);
        cyc(); cyc();
        check(err == 1 && evt_valid == 0, "R9", "still blocked", 64'({err, evt_valid}), 64'(2'b10));
        l2_hit = 0;
        cyc();
        check(err == 0, "R9", "err clears", 64'(err), 0);
        check(evt_valid == 1 && evt_code == 3'd0, "R9", "issue after clear",
              64'({evt_valid, evt_code}), 64'({1'b1, 3'd0}));

        // R11: one-cycle gap, then next decision from current inputs
        evt_ready = 1;
        cyc();
        evt_ready = 0;
        check(evt_valid == 0, "R11", "gap after accept", 64'(evt_valid), 0);
        req_kind = 2'd1; dl1_hit = 0; il1_hit = 1;
        cyc();
        check(evt_valid == 1 && evt_code == 3'd1, "R11", "next decision",
              64'({evt_valid, evt_code}), 64'({1'b1, 3'd1}));
        evt_ready = 1;
        cyc();
        evt_ready = 0; req_valid = 0; clear_lookup();
        cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule